// File: doc/BRIEF.md
# Motor Fault Supervisor

This block gathers every protection input of a two-bridge brushed motor controller and decides which bridge may drive. Each bridge has an overcurrent comparator and a gate pre-driver fault flag. The chip as a whole has an over-temperature flag and a supply-undervoltage flag. The overcurrent comparators are deglitched by a counter: the comparator must stay asserted without a break for a programmable time before the block acts on it.

Faults that belong to a single bridge are held in a latch. That latch turns off only its own bridge and stays set until software clears it. The two chip-wide faults turn off both bridges and release them on their own once the flag drops. The block sends a set request for each fault to the status register and takes per-bit clear strobes back from it.

The block also produces an active-low fault pin. It passes the overcurrent threshold code through unchanged to the external comparator.

Top module: `motor_fault_supervisor`

## Requirements
- R1: Overcurrent on a channel is recognised only when its comparator is sampled high on DEG_BASE << deg_sel_i consecutive rising clock edges, with deg_sel_i = 0..3. A run one edge shorter is not recognised.
- R2: If the comparator is sampled low before the count completes, the deglitch count restarts from zero. Two short runs separated by a low cycle never add up.
- R3: A recognised overcurrent raises ocp_set_o for one cycle and latches that channel's fault. The latch turns off only that channel's bridge. It stays set until a one-cycle ocp_clr_i strobe for that channel arrives.
- R4: A high pdf_i on a channel latches that channel's fault and turns off only its bridge. pdf_set_o follows pdf_i. The latch is released only by a pdf_clr_i strobe.
- R5: When a set condition and a clear strobe for the same latch fall in the same cycle, the set wins and the bridge stays off.
- R6: ot_i is registered once. While the registered value is high, ots_o is 1 and both bridges are off. Both recover one cycle after ot_i falls, with no clear.
- R7: uv_i is registered once. While the registered value is high, uvlo_o is 1 and both bridges are off. Both recover one cycle after uv_i falls.
- R8: fault_n_o is 0 exactly while any per-channel latch is set or ots_o or uvlo_o is 1. The enable and sleep inputs do not pull it low.
- R9: enable_i = 0 or sleep_i = 1 turns off both bridges immediately, and the latches are left as they were.
- R10: oc_thr_o always equals oc_thr_i.
- R11: After reset, all latches are clear, ots_o, uvlo_o and all set outputs are 0, and fault_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Bridge enable; 0 turns off both bridges |
| sleep_i | input | 1 | Sleep request; 1 turns off both bridges |
| deg_sel_i | input | 2 | Deglitch time code; the time is DEG_BASE << code cycles |
| oc_thr_i | input | 2 | Overcurrent threshold code |
| oc_thr_o | output | 2 | Threshold code passed to the comparator |
| ocp_cmp_i | input | NCH | Overcurrent comparator, one bit per channel |
| pdf_i | input | NCH | Pre-driver fault flag, one bit per channel |
| ot_i | input | 1 | Over-temperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| ocp_clr_i | input | NCH | Clear strobe for the overcurrent latches |
| pdf_clr_i | input | NCH | Clear strobe for the pre-driver latches |
| ocp_set_o | output | NCH | Overcurrent set request to the status register |
| pdf_set_o | output | NCH | Pre-driver set request to the status register |
| ots_o | output | 1 | Over-temperature status |
| uvlo_o | output | 1 | Undervoltage status |
| bridge_off_o | output | NCH | Per-channel bridge disable |
| fault_n_o | output | 1 | Active-low fault pin |

## Verification
Two events can land in the same cycle: a clear strobe from software and a fresh recognition of the fault it is clearing. The bench provokes this for overcurrent. It latches a fault, then holds the comparator for exactly one edge fewer than the deglitch time, so the recognition is pending, and raises the clear strobe in that same cycle. It provokes it for the pre-driver path by strobing the clear while the fault flag is still high. In both cases the bench judges the result at the ports: the bridge must still be off and the fault pin still low. A lone clear strobe afterwards must release the bridge.

// File: rtl/mfs_pkg.sv
// Shared helpers for the motor fault supervisor.
// Assumes deglitch times are binary multiples of one base count.
package mfs_pkg;
    // Number of consecutive comparator edges needed for a given code.
    function automatic int unsigned deg_limit(input logic [1:0] sel, input int unsigned base);
        return base << sel;
    endfunction
endpackage

// File: rtl/mfs_ocp_deglitch.sv
// Overcurrent deglitch counter for one channel.
// Counts rising edges on which the comparator is high; any low sample
// restarts the count. hit_o is high in the cycle whose next edge completes
// the run. Assumes DEG_BASE >= 2.
module mfs_ocp_deglitch
    import mfs_pkg::*;
#(
    parameter int unsigned DEG_BASE = 263,
    localparam int CW = $clog2(DEG_BASE * 8) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       cmp_i,
    output logic       hit_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    // Last count value before recognition for the selected code.
    always_comb lim_m1 = CW'(deg_limit(sel_i, DEG_BASE) - 1);

    // Recognition: comparator still high with the run complete.
    always_comb hit_o = cmp_i && (cnt_q >= lim_m1);

    // Run-length counter, cleared by a low sample or a recognition.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!cmp_i || hit_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mfs_fault_latch.sv
// Sticky fault bit with set priority over clear.
// Assumes the clear is a strobe from the status register.
module mfs_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Set dominates; clear acts only when no set is present.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/motor_fault_supervisor.sv
// Protection combiner for an NCH-bridge motor controller.
// Per-channel faults (deglitched overcurrent, pre-driver) latch until
// cleared and stop only their own bridge. Chip-wide faults (temperature,
// supply) are registered once and stop every bridge while present.
// Assumes all flag inputs are already synchronous to clk.
module motor_fault_supervisor #(
    parameter int unsigned NCH      = 2,
    parameter int unsigned DEG_BASE = 263
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable_i,
    input  logic           sleep_i,
    input  logic [1:0]     deg_sel_i,
    input  logic [1:0]     oc_thr_i,
    output logic [1:0]     oc_thr_o,
    input  logic [NCH-1:0] ocp_cmp_i,
    input  logic [NCH-1:0] pdf_i,
    input  logic           ot_i,
    input  logic           uv_i,
    input  logic [NCH-1:0] ocp_clr_i,
    input  logic [NCH-1:0] pdf_clr_i,
    output logic [NCH-1:0] ocp_set_o,
    output logic [NCH-1:0] pdf_set_o,
    output logic           ots_o,
    output logic           uvlo_o,
    output logic [NCH-1:0] bridge_off_o,
    output logic           fault_n_o
);
    logic [NCH-1:0] ocp_hit;
    logic [NCH-1:0] ocp_lat;
    logic [NCH-1:0] pdf_lat;
    logic           ot_q;
    logic           uv_q;
    logic           global_off;

    // Threshold code goes straight to the external comparator.
    always_comb oc_thr_o = oc_thr_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mfs_ocp_deglitch #(.DEG_BASE(DEG_BASE)) i_deg (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_i (deg_sel_i),
            .cmp_i (ocp_cmp_i[c]),
            .hit_o (ocp_hit[c])
        );
        mfs_fault_latch i_ocp_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ocp_hit[c]),
            .clr_i (ocp_clr_i[c]),
            .q_o   (ocp_lat[c])
        );
        mfs_fault_latch i_pdf_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (pdf_i[c]),
            .clr_i (pdf_clr_i[c]),
            .q_o   (pdf_lat[c])
        );
    end

    // Register the chip-wide flags once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ot_q <= 1'b0;
            uv_q <= 1'b0;
        end else begin
            ot_q <= ot_i;
            uv_q <= uv_i;
        end
    end

    // Set requests and status to the register file.
    always_comb begin
        ocp_set_o = ocp_hit;
        pdf_set_o = pdf_i;
        ots_o     = ot_q;
        uvlo_o    = uv_q;
    end

    // Bridge disables: own latches, chip-wide faults, enable and sleep.
    always_comb begin
        global_off   = ot_q || uv_q || !enable_i || sleep_i;
        bridge_off_o = ocp_lat | pdf_lat | {NCH{global_off}};
    end

    // Fault pin: low while any fault is present or latched.
    always_comb fault_n_o = !(|ocp_lat || |pdf_lat || ot_q || uv_q);
endmodule

// File: rtl/mfs_checker.sv
// Temporal checks on the supervisor ports; attached with bind below.
module mfs_checker #(
    parameter int unsigned NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable_i,
    input logic           sleep_i,
    input logic [NCH-1:0] ocp_cmp_i,
    input logic [NCH-1:0] ocp_set_o,
    input logic [NCH-1:0] pdf_set_o,
    input logic           ots_o,
    input logic           uvlo_o,
    input logic [NCH-1:0] bridge_off_o,
    input logic           fault_n_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R1
        deglitch_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ocp_set_o[c] |-> ocp_cmp_i[c] && $past(ocp_cmp_i[c]));
        // R3
        ocp_latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ocp_set_o[c] |=> bridge_off_o[c] && !fault_n_o);
        // R5
        pdf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pdf_set_o[c] |=> bridge_off_o[c] && !fault_n_o);
    end
    // R6
    ots_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ots_o |-> (&bridge_off_o) && !fault_n_o);
    // R7
    uvlo_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_o |-> (&bridge_off_o) && !fault_n_o);
    // R9
    idle_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i || sleep_i) |-> (&bridge_off_o));
    // R8
    pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n_o && enable_i && !sleep_i) |-> (bridge_off_o == '0));
endmodule

bind motor_fault_supervisor mfs_checker #(.NCH(NCH)) i_mfs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .sleep_i      (sleep_i),
    .ocp_cmp_i    (ocp_cmp_i),
    .ocp_set_o    (ocp_set_o),
    .pdf_set_o    (pdf_set_o),
    .ots_o        (ots_o),
    .uvlo_o       (uvlo_o),
    .bridge_off_o (bridge_off_o),
    .fault_n_o    (fault_n_o)
);

// File: tb/test_motor_fault_supervisor.sv
module test_motor_fault_supervisor;
    localparam int NCH  = 2;
    localparam int BASE = 263;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b1, sleep_i = 1'b0;
    logic [1:0] deg_sel_i = 2'b00, oc_thr_i = 2'b01, oc_thr_o;
    logic [NCH-1:0] ocp_cmp_i = '0, pdf_i = '0, ocp_clr_i = '0, pdf_clr_i = '0;
    logic ot_i = 1'b0, uv_i = 1'b0;
    logic [NCH-1:0] ocp_set_o, pdf_set_o, bridge_off_o;
    logic ots_o, uvlo_o, fault_n_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    motor_fault_supervisor #(.NCH(NCH), .DEG_BASE(BASE)) i_motor_fault_supervisor (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold channel comparator high for n rising edges; returns set pulses seen.
    task automatic run_cmp(input int ch, input int n, output int pulses);
        pulses = 0;
        @(negedge clk) ocp_cmp_i[ch] = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k < n - 1) pulses += ocp_set_o[ch];
        end
        ocp_cmp_i[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_ocp(input int ch);
        @(negedge clk) ocp_clr_i[ch] = 1'b1;
        @(negedge clk) ocp_clr_i[ch] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 bridge_off", bridge_off_o, 0);
        chk("R11 fault_n", fault_n_o, 1);
        chk("R11 ots/uvlo", {ots_o, uvlo_o}, 0);
        chk("R11 set outs", {ocp_set_o, pdf_set_o}, 0);
        chk("R10 threshold", oc_thr_o, 1);
        @(negedge clk) oc_thr_i = 2'b10;
        #1 chk("R10 threshold change", oc_thr_o, 2);
    endtask

    task automatic t_deglitch();
        int p;
        run_cmp(0, BASE - 1, p);
        chk("R1 short run ignored", bridge_off_o, 0);
        run_cmp(0, BASE, p);
        chk("R1 full run set pulse", p, 1);
        chk("R3 own bridge off only", bridge_off_o, 1);
        chk("R3 fault pin low", fault_n_o, 0);
        repeat (5) @(negedge clk);
        chk("R3 latch holds", bridge_off_o, 1);
        clear_ocp(0);
        chk("R3 clear releases", bridge_off_o, 0);
        chk("R8 pin released", fault_n_o, 1);
        // R2: two short runs with a low gap never add up
        run_cmp(1, BASE - 1, p);
        run_cmp(1, BASE - 1, p);
        chk("R2 restart after gap", bridge_off_o, 0);
        // longest code
        @(negedge clk) deg_sel_i = 2'b11;
        run_cmp(1, 8 * BASE - 1, p);
        chk("R1 code 3 short", bridge_off_o, 0);
        run_cmp(1, 8 * BASE, p);
        chk("R1 code 3 full", bridge_off_o, 2);
        clear_ocp(1);
        chk("R3 ch1 cleared", bridge_off_o, 0);
        @(negedge clk) deg_sel_i = 2'b00;
    endtask

    task automatic t_coincide();
        int p;
        run_cmp(0, BASE, p);
        chk("R5 pre-latch", bridge_off_o, 1);
        @(negedge clk) ocp_cmp_i[0] = 1'b1;
        repeat (BASE - 1) @(negedge clk);
        ocp_clr_i[0] = 1'b1;
        @(negedge clk) begin ocp_clr_i[0] = 1'b0; ocp_cmp_i[0] = 1'b0; end
        @(negedge clk);
        chk("R5 ocp set beats clear", bridge_off_o, 1);
        clear_ocp(0);
        chk("R5 lone clear releases", bridge_off_o, 0);
    endtask

    task automatic t_pdf();
        @(negedge clk) pdf_i[1] = 1'b1;
        #1 chk("R4 set follows flag", pdf_set_o, 2);
        @(negedge clk) pdf_i[1] = 1'b0;
        chk("R4 own bridge off", bridge_off_o, 2);
        @(negedge clk) begin pdf_i[1] = 1'b1; pdf_clr_i[1] = 1'b1; end
        @(negedge clk) begin pdf_i[1] = 1'b0; pdf_clr_i[1] = 1'b0; end
        chk("R5 pdf set beats clear", bridge_off_o, 2);
        @(negedge clk) pdf_clr_i[1] = 1'b1;
        @(negedge clk) pdf_clr_i[1] = 1'b0;
        chk("R4 clear releases", bridge_off_o, 0);
        chk("R8 pin after pdf", fault_n_o, 1);
    endtask

    task automatic t_global();
        @(negedge clk) ot_i = 1'b1;
        #1 chk("R6 one-cycle latency", bridge_off_o, 0);
        @(negedge clk);
        chk("R6 both off", bridge_off_o, 3);
        chk("R6 ots", ots_o, 1);
        chk("R8 pin low ot", fault_n_o, 0);
        ot_i = 1'b0;
        @(negedge clk);
        chk("R6 self recover", {ots_o, bridge_off_o, fault_n_o}, 1);
        @(negedge clk) uv_i = 1'b1;
        @(negedge clk);
        chk("R7 both off", {uvlo_o, bridge_off_o, fault_n_o}, 14);
        uv_i = 1'b0;
        @(negedge clk);
        chk("R7 self recover", {uvlo_o, bridge_off_o, fault_n_o}, 1);
    endtask

    task automatic t_enable();
        @(negedge clk) enable_i = 1'b0;
        #1 chk("R9 disable both", bridge_off_o, 3);
        chk("R8 pin unaffected by enable", fault_n_o, 1);
        @(negedge clk) begin enable_i = 1'b1; sleep_i = 1'b1; end
        #1 chk("R9 sleep both", bridge_off_o, 3);
        chk("R8 pin unaffected by sleep", fault_n_o, 1);
        @(negedge clk) sleep_i = 1'b0;
        #1 chk("R9 resume", bridge_off_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_deglitch();
        t_coincide();
        t_pdf();
        t_global();
        t_enable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule